// File: doc/BRIEF.md
# Two-Type DMA Channel Scheduler

This block decides which of several DMA channels may use a shared data mover, and keeps track of how many items each channel still has to move. Each channel is armed by writing a 32-bit control word. The word sets the transfer type, the item count and the group size. A single-type channel is served one item for each request pulse from its peripheral. A burst-type channel needs one trigger pulse. After that it is served in groups of items until its whole count has been moved.

The mover is granted one service unit at a time. A service unit is one item for a single-type channel, or one group for a burst-type channel. The mover reports each finished item with a one-cycle strobe. The channel to serve is chosen only at unit boundaries, by fixed priority: the highest channel number with outstanding work wins. A single-type request that arrives while another channel's group is running is held until it can be served. When a channel's last item completes, that channel raises a sticky done flag and stops taking requests. Address generation and bus signalling belong to the mover.

Top module: `dma_tx_sched`

## Requirements
- R1: After reset, `grant_o` is low, every bit of `done_o` is low and every channel is unarmed, so a request pulse to a channel that was never configured produces no grant.
- R2: A write (`cfg_we_i` high) to channel `cfg_ch_i` arms that channel and clears its done flag. Bit 2 of `cfg_ctl_i` selects the type (0 = single, 1 = burst). Bits [31:16] hold a count N, and the channel moves N+1 items. Bits [6:4] hold a group code.
- R3: A single-type channel gets a service unit of exactly one item for each request pulse, whatever value the group code holds.
- R4: A burst-type channel needs one request pulse. It is then served in groups of 128 >> code items (code 0 gives 128, code 7 gives 1). The final group is shortened to the items that remain. No further pulses are needed.
- R5: When several channels have work at a unit boundary, the highest-numbered channel is served first.
- R6: Once granted, `grant_o` and `cur_ch_o` hold until the done strobe for the unit's last item, including while the strobe is absent. After each unit, `grant_o` is low for one cycle before the next unit starts.
- R7: A single-type request that arrives while another channel's group is in progress is remembered. It is served right after that group, and the burst channel then continues with its next group.
- R8: When a channel's last item is strobed, its bit in `done_o` rises and stays high until that channel is rewritten. The channel then ignores request pulses.
- R9: `item_done_i` has no effect while `grant_o` is low.
- R10: A configuration write to the channel currently being served is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_ch_i | input | $clog2(NCH) | Channel addressed by the write |
| cfg_ctl_i | input | 32 | Control word: count [31:16], group code [6:4], type [2] |
| req_i | input | NCH | Per-channel request / trigger pulses |
| item_done_i | input | 1 | Mover strobe: one item finished |
| grant_o | output | 1 | A service unit is granted to the mover |
| cur_ch_o | output | $clog2(NCH) | Channel of the granted unit |
| done_o | output | NCH | Sticky per-channel completion flags |

## Verification
The bench replays a table of burst configurations chosen so that the final group is shortened, exact or a single item. A scheduler that decremented the count by a full group, or that forgot to truncate, would report the wrong number of units or the wrong last length. A single-type channel is programmed with the largest group code. This shows whether a design wrongly used that field and served one request as a group. A high-priority single request is injected in the middle of a 128-item group. A design that preempted the group, or dropped the remembered request, would produce a unit sequence other than 1, 128, 1, 128. A control write to the channel in service, and done strobes with no grant, would shorten or reshape the transfer if either were accepted.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  localparam int CTL_W    = 32;
  localparam int CNT_LSB  = 16;
  localparam int CNT_W    = 16;
  localparam int TYPE_BIT = 2;
  localparam int CODE_LSB = 4;
  localparam int CODE_W   = 3;
  localparam int UNIT_W   = 8;
  localparam int MAX_GRP  = 1 << (UNIT_W - 1);

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [UNIT_W-1:0] unit_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic {XFER_SINGLE = 1'b0, XFER_BURST = 1'b1} xfer_e;
  typedef enum logic {SCH_IDLE = 1'b0, SCH_SERVE = 1'b1} sch_state_e;

  // Length of the next service unit for a channel with rem+1 items left.
  function automatic unit_t unit_len(xfer_e t, code_t code, cnt_t rem);
    logic [CNT_W:0] left;
    logic [CNT_W:0] grp;
    left = {1'b0, rem} + (CNT_W+1)'(1);
    grp  = (CNT_W+1)'(MAX_GRP) >> code;
    if (t == XFER_SINGLE) return unit_t'(1);
    if (left < grp)       return unit_t'(left);
    return unit_t'(grp);
  endfunction
endpackage

// File: rtl/dsch_chan.sv
module dsch_chan
  import dsch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_we,
  input  xfer_e cfg_type,
  input  cnt_t  cfg_cnt,
  input  code_t cfg_code,
  input  logic  req,
  input  logic  in_service,
  input  logic  serve_item,
  output logic  elig,
  output xfer_e xtype,
  output cnt_t  rem,
  output code_t code,
  output logic  done
);
  logic  en_q,   en_d;
  logic  pend_q, pend_d;
  xfer_e type_q, type_d;
  cnt_t  rem_q,  rem_d;
  code_t code_q, code_d;
  logic  done_q, done_d;
  logic  last;
  logic  upd;

  assign last = (rem_q == '0);
  assign upd  = cfg_we | serve_item | req;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    type_d = type_q;
    rem_d  = rem_q;
    code_d = code_q;
    done_d = done_q;
    if (cfg_we && !in_service) begin
      en_d   = 1'b1;
      pend_d = 1'b0;
      type_d = cfg_type;
      rem_d  = cfg_cnt;
      code_d = cfg_code;
      done_d = 1'b0;
    end else begin
      if (serve_item) begin
        if (last) begin
          en_d   = 1'b0;
          pend_d = 1'b0;
          done_d = 1'b1;
        end else begin
          rem_d = rem_q - cnt_t'(1);
          if (type_q == XFER_SINGLE) pend_d = 1'b0;
        end
      end
      if (req && en_d) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      type_q <= XFER_SINGLE;
      rem_q  <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else if (upd) begin
      en_q   <= en_d;
      pend_q <= pend_d;
      type_q <= type_d;
      rem_q  <= rem_d;
      code_q <= code_d;
      done_q <= done_d;
    end
  end

  assign elig  = en_q & pend_q;
  assign xtype = type_q;
  assign rem   = rem_q;
  assign code  = code_q;
  assign done  = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !cfg_we |=> done_q); // R8
  AST_NO_PEND_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pend_q); // R8
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    serve_item && !last |=> rem_q == cnt_t'($past(rem_q) - 1'b1)); // R2
  AST_CFG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && in_service && !serve_item |=> $stable(rem_q) && $stable(type_q)); // R10
endmodule

// File: rtl/dsch_arb.sv
module dsch_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] elig,
  output logic           valid,
  output logic [CHW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i]) idx = CHW'(i);
    end
  end
  assign valid = |elig;
endmodule

// File: rtl/dsch_unit.sv
module dsch_unit
  import dsch_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pick_valid,
  input  logic [CHW-1:0] pick_idx,
  input  unit_t          pick_len,
  input  logic           item_done,
  output logic           grant,
  output logic [CHW-1:0] cur_ch,
  output logic           unit_last
);
  sch_state_e     state_q, state_d;
  unit_t          left_q,  left_d;
  logic [CHW-1:0] ch_q,    ch_d;
  logic           upd;

  assign upd = (state_q == SCH_IDLE) ? pick_valid : item_done;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    ch_d    = ch_q;
    case (state_q)
      SCH_IDLE: begin
        if (pick_valid) begin
          state_d = SCH_SERVE;
          left_d  = pick_len;
          ch_d    = pick_idx;
        end
      end
      default: begin
        if (item_done) begin
          if (left_q == unit_t'(1)) state_d = SCH_IDLE;
          else                      left_d  = left_q - unit_t'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_IDLE;
      left_q  <= '0;
      ch_q    <= '0;
    end else if (upd) begin
      state_q <= state_d;
      left_q  <= left_d;
      ch_q    <= ch_d;
    end
  end

  assign grant     = (state_q == SCH_SERVE);
  assign cur_ch    = ch_q;
  assign unit_last = grant & item_done & (left_q == unit_t'(1));

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !item_done |=> grant && $stable(cur_ch)); // R6
  AST_GAP_AFTER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    unit_last |=> !grant); // R6
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant && pick_valid |-> pick_len != '0); // R4
endmodule

// File: rtl/dma_tx_sched.sv
module dma_tx_sched
  import dsch_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [CHW-1:0]   cfg_ch_i,
  input  logic [CTL_W-1:0] cfg_ctl_i,
  input  logic [NCH-1:0]   req_i,
  input  logic             item_done_i,
  output logic             grant_o,
  output logic [CHW-1:0]   cur_ch_o,
  output logic [NCH-1:0]   done_o
);
  xfer_e          f_type;
  cnt_t           f_cnt;
  code_t          f_code;
  logic           unused_ctl;
  logic [NCH-1:0] elig_v;
  xfer_e          type_v [NCH];
  cnt_t           rem_v  [NCH];
  code_t          code_v [NCH];
  logic           pick_valid;
  logic [CHW-1:0] pick_idx;
  unit_t          pick_len;
  logic           unit_last;

  assign f_type = xfer_e'(cfg_ctl_i[TYPE_BIT]);
  assign f_cnt  = cfg_ctl_i[CNT_LSB +: CNT_W];
  assign f_code = cfg_ctl_i[CODE_LSB +: CODE_W];
  assign unused_ctl = ^{cfg_ctl_i[CNT_LSB-1:CODE_LSB+CODE_W],
                        cfg_ctl_i[CODE_LSB-1:TYPE_BIT+1],
                        cfg_ctl_i[TYPE_BIT-1:0], unit_last};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_wr, in_srv;
    assign sel_wr = cfg_we_i && (cfg_ch_i == CHW'(g));
    assign in_srv = grant_o && (cur_ch_o == CHW'(g));
    dsch_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (sel_wr),
      .cfg_type   (f_type),
      .cfg_cnt    (f_cnt),
      .cfg_code   (f_code),
      .req        (req_i[g]),
      .in_service (in_srv),
      .serve_item (in_srv & item_done_i),
      .elig       (elig_v[g]),
      .xtype      (type_v[g]),
      .rem        (rem_v[g]),
      .code       (code_v[g]),
      .done       (done_o[g])
    );
  end

  dsch_arb #(.NCH(NCH)) u_arb (
    .elig  (elig_v),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  assign pick_len = unit_len(type_v[pick_idx], code_v[pick_idx], rem_v[pick_idx]);

  dsch_unit #(.NCH(NCH)) u_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .pick_len   (pick_len),
    .item_done  (item_done_i),
    .grant      (grant_o),
    .cur_ch     (cur_ch_o),
    .unit_last  (unit_last)
  );

  AST_PICK_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (elig_v >> pick_idx) == NCH'(1)); // R5
  AST_IDLE_STROBE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_o && item_done_i && !cfg_we_i |=> $stable(done_o)); // R9
endmodule

// File: tb/dma_tx_sched_tb.sv
module dma_tx_sched_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  code;
    logic [15:0] cnt;
    logic [8:0]  units;
    logic [8:0]  full;
    logic [8:0]  last;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd7, 16'd3,   9'd4, 9'd1,   9'd1},
    '{3'd6, 16'd4,   9'd3, 9'd2,   9'd1},
    '{3'd5, 16'd7,   9'd2, 9'd4,   9'd4},
    '{3'd0, 16'd9,   9'd1, 9'd10,  9'd10},
    '{3'd4, 16'd19,  9'd3, 9'd8,   9'd4},
    '{3'd0, 16'd255, 9'd2, 9'd128, 9'd128}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we_i;
  logic [1:0]  cfg_ch_i;
  logic [31:0] cfg_ctl_i;
  logic [3:0]  req_i;
  logic        item_done_i;
  logic        grant_o;
  logic [1:0]  cur_ch_o;
  logic [3:0]  done_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int rec_ch  [32];
  int rec_len [32];
  int rec_n;
  int rec_items;

  dma_tx_sched #(.NCH(4)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_ctl(logic burst, logic [2:0] code, logic [15:0] cnt);
    return {cnt, 9'd0, code, 1'b0, burst, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input logic [31:0] ctl);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(ch); cfg_ctl_i = ctl;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    req_i = m;
    @(negedge clk);
    req_i = '0;
  endtask

  // Mover model: strobes item_done every granted cycle and logs units.
  task automatic record(input int stop_units, input logic [3:0] stop_done,
                        input int inj_at, input logic [3:0] inj_req);
    int cur = 0;
    int lim = 0;
    bit g;
    bit injd = 0;
    rec_n = 0; rec_items = 0;
    forever begin
      @(negedge clk);
      g = grant_o;
      req_i = '0;
      if (!injd && inj_at >= 0 && rec_items == inj_at) begin
        req_i = inj_req; injd = 1;
      end
      item_done_i = g;
      if (g) begin
        if (cur == 0 && rec_n < 32) rec_ch[rec_n] = int'(cur_ch_o);
        cur++; rec_items++;
      end else if (cur > 0) begin
        if (rec_n < 32) rec_len[rec_n] = cur;
        rec_n++; cur = 0;
      end
      if (!g && ((stop_units > 0 && rec_n >= stop_units) ||
                 (stop_done != 0 && (done_o & stop_done) == stop_done))) break;
      lim++;
      if (lim > 5000) begin
        chk(0, "record timeout", lim, 0);
        break;
      end
    end
    item_done_i = 1'b0;
    req_i = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we_i = 1'b0; cfg_ch_i = '0; cfg_ctl_i = '0;
    req_i = '0; item_done_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grant_o == 1'b0, "R1 grant after reset", int'(grant_o), 0);
    chk(done_o == 4'b0, "R1 done after reset", int'(done_o), 0);
    pulse(4'b1111);
    repeat (3) @(negedge clk);
    chk(grant_o == 1'b0, "R1 unarmed request", int'(grant_o), 0);

    // Table walk: burst groups and truncation (R4, R2, R6)
    foreach (VECS[k]) begin
      cfg(0, mk_ctl(1'b1, VECS[k].code, VECS[k].cnt));
      chk(done_o[0] == 1'b0, "R2 done cleared by write", int'(done_o[0]), 0);
      pulse(4'b0001);
      record(0, 4'b0001, -1, 4'b0);
      chk(rec_n == int'(VECS[k].units), "R4 unit count", rec_n, int'(VECS[k].units));
      chk(rec_items == int'(VECS[k].cnt) + 1, "R2 item total", rec_items, int'(VECS[k].cnt) + 1);
      chk(rec_len[rec_n-1] == int'(VECS[k].last), "R4 last group", rec_len[rec_n-1], int'(VECS[k].last));
      for (int u = 0; u < rec_n - 1; u++)
        chk(rec_len[u] == int'(VECS[k].full), "R4 full group", rec_len[u], int'(VECS[k].full));
      chk(done_o[0] == 1'b1, "R8 done raised", int'(done_o[0]), 1);
    end

    // R5/R7: simultaneous trigger, mid-group single request
    cfg(0, mk_ctl(1'b1, 3'd0, 16'd255));
    cfg(1, mk_ctl(1'b0, 3'd0, 16'd1));
    pulse(4'b0011);
    record(0, 4'b0011, 10, 4'b0010);
    chk(rec_n == 4, "R7 unit sequence length", rec_n, 4);
    chk(rec_ch[0] == 1 && rec_len[0] == 1, "R5 ch1 first", rec_ch[0], 1);
    chk(rec_ch[1] == 0 && rec_len[1] == 128, "R7 group not preempted", rec_len[1], 128);
    chk(rec_ch[2] == 1 && rec_len[2] == 1, "R7 latched single served", rec_ch[2], 1);
    chk(rec_ch[3] == 0 && rec_len[3] == 128, "R7 burst resumes", rec_len[3], 128);

    // R5: priority among higher channels
    cfg(3, mk_ctl(1'b0, 3'd0, 16'd0));
    cfg(1, mk_ctl(1'b0, 3'd0, 16'd0));
    pulse(4'b1010);
    record(0, 4'b1010, -1, 4'b0);
    chk(rec_n == 2 && rec_ch[0] == 3, "R5 ch3 over ch1", rec_ch[0], 3);
    chk(rec_ch[1] == 1, "R5 ch1 second", rec_ch[1], 1);

    // R8: finished channel ignores requests, flag sticks
    pulse(4'b1000);
    repeat (4) begin
      @(negedge clk);
      chk(grant_o == 1'b0, "R8 request after done", int'(grant_o), 0);
    end
    chk(done_o[3] == 1'b1, "R8 flag sticky", int'(done_o[3]), 1);

    // R3/R9: single type with code 0, stray strobes while idle
    cfg(2, mk_ctl(1'b0, 3'd0, 16'd2));
    repeat (3) begin
      @(negedge clk); item_done_i = 1'b1;
    end
    @(negedge clk); item_done_i = 1'b0;
    for (int r = 0; r < 3; r++) begin
      pulse(4'b0100);
      record(1, 4'b0, -1, 4'b0);
      chk(rec_n == 1 && rec_ch[0] == 2 && rec_len[0] == 1, "R3 one item per request", rec_len[0], 1);
      chk(done_o[2] == (r == 2), "R9 count unaffected by idle strobes", int'(done_o[2]), int'(r == 2));
    end

    // R10/R6: write to served channel during a stall
    cfg(0, mk_ctl(1'b1, 3'd5, 16'd7));
    pulse(4'b0001);
    @(negedge clk);
    chk(grant_o == 1'b1 && cur_ch_o == 2'd0, "R6 grant for ch0", int'(grant_o), 1);
    cfg_we_i = 1'b1; cfg_ch_i = 2'd0; cfg_ctl_i = mk_ctl(1'b0, 3'd0, 16'd0);
    @(negedge clk);
    cfg_we_i = 1'b0;
    chk(grant_o == 1'b1 && cur_ch_o == 2'd0, "R6 hold while stalled", int'(grant_o), 1);
    record(0, 4'b0001, -1, 4'b0);
    chk(rec_n == 2 && rec_len[0] == 4 && rec_len[1] == 4, "R10 write ignored", rec_items, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule